// File: doc/BRIEF.md
# Low-power seconds counter with alarm

A real-time-clock peripheral. A 47-bit counter advances once per edge of a slow clock (nominally 32.768 kHz). The low 15 bits are a sub-second fraction and the upper 32 bits are whole seconds. A 32-bit seconds comparator raises a sticky alarm flag, which drives an interrupt output and a wakeup output through separate enables. Software reaches the block over a simple 32-bit register bus that runs on a fast clock.

The counter lives in the slow domain. The control enables cross into it through synchronizers. The enable state actually applied there is sent back, so software can poll for it. The counter value is returned Gray-coded, so two back-to-back reads agree once the count is steady. A 47-bit value spans two registers and has no snapshot, so software repeats the pair of reads until two passes match. The counter can only be loaded while it is stopped. A pattern register supports glitch detection: a status bit stays set until the expected word has been written.

Top module: `lp_rtc`

## Requirements
- R1: After reset all of the following hold: control reads 0, counter low and high read 0, alarm reads 0, status bit 0 (alarm hit) is 0, status bit 1 (glitch) is 1, and `irq_o` and `wake_o` are low.
- R2: Counter bits 31:0 read at offset 0x20. Counter bits 46:32 read at offset 0x1C in bits 14:0, and bits 31:15 of that word read zero. While running, the counter gains one per slow-clock edge, carrying from the fraction into the seconds and from the low word into the high word.
- R3: Writes to 0x20 and 0x1C load the counter only while control bit 0 is clear both as written and as read back. At any other time these writes are ignored.
- R4: Control bit 0 (counter enable) reads back the state applied in the slow domain. A changed setting is not visible on the read issued right after the write, and becomes visible within 8 slow-clock periods.
- R5: While the counter is disabled its value holds, and repeated reads return the same 47-bit value.
- R6: With control bit 1 (alarm enable) set, status bit 0 is set when counter bits 46:15 equal the value at offset 0x24. With control bit 1 clear, a match does not set it.
- R7: A write to the alarm register at 0x24 is ignored while control bit 1 is set.
- R8: Status bit 0 stays set until a status write (offset 0x18) with bit 0 equal to 1 clears it. Writing 0 there has no effect.
- R9: `irq_o` is high exactly while status bit 0 and control bit 1 are both set. `wake_o` is high exactly while status bit 0 and control bit 3 (wakeup enable) are both set.
- R10: Offset 0x30 reads back the last word written to it. Status bit 1 is set unless that word is 0x41736166.
- R11: Reads of any offset other than 0x04, 0x18, 0x1C, 0x20, 0x24 and 0x30 return 0. Read data appears on `rdata_o` on the clock edge after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bus clock |
| slow_clk_i | input | 1 | Slow counting clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Alarm wakeup request |

## Verification
The hardest states to reach are the carries: fraction into seconds, and low word into high word. In real time each takes 2^15 or 2^32 slow ticks. The bench stops the counter, loads it a few dozen ticks short of each boundary, restarts it, and checks the value after a measured number of slow periods. The alarm match is reached the same way, by loading a count just below the alarm second. The bench then brings out the enable gating and the write-1-to-clear behaviour at the output pins while the match second is still current.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_ALARM  = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_GLITCH = 8'h30;

  localparam int unsigned CTRL_CNT_EN  = 0;
  localparam int unsigned CTRL_ALM_EN  = 1;
  localparam int unsigned CTRL_WAKE_EN = 3;
  localparam int unsigned STAT_ALM     = 0;
  localparam int unsigned STAT_GLITCH  = 1;

  localparam logic [BUS_W-1:0] GLITCH_WORD = 32'h4173_6166;

  typedef struct packed {
    logic wake_en;
    logic alm_en;
    logic cnt_en;
  } ctrl_t;
endpackage

// File: rtl/lp_rtc_sync.sv
module lp_rtc_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lp_rtc_slow_core.sv
module lp_rtc_slow_core #(
  parameter int unsigned CNT_W       = 47,
  parameter int unsigned FRAC_W      = 15,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEC_W = CNT_W - FRAC_W,
  localparam int unsigned LO_W  = 32,
  localparam int unsigned HI_W  = CNT_W - LO_W
) (
  input  logic             slow_clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             alm_en_i,
  input  logic [SEC_W-1:0] alarm_sec_i,
  input  logic             lo_tog_i,
  input  logic             hi_tog_i,
  input  logic [LO_W-1:0]  load_lo_i,
  input  logic [HI_W-1:0]  load_hi_i,
  output logic [CNT_W-1:0] cnt_gray_o,
  output logic             cnt_en_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [3:0]       in_d, in_s;
  logic             en_q, alm_q, lo_prev_q, hi_prev_q, hit_q;
  logic             load_lo, load_hi;
  logic [CNT_W-1:0] cnt_q, cnt_d, gray_q;

  assign in_d = {hi_tog_i, lo_tog_i, alm_en_i, cnt_en_i};

  lp_rtc_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk_i (slow_clk_i),
    .rst_ni(rst_ni),
    .d_i   (in_d),
    .q_o   (in_s)
  );

  assign load_lo = in_s[2] ^ lo_prev_q;
  assign load_hi = in_s[3] ^ hi_prev_q;

  // load beats increment; bus only issues loads while stopped
  always_comb begin
    cnt_d = cnt_q;
    if (en_q) cnt_d = cnt_q + CNT_ONE;
    if (load_lo) cnt_d[LO_W-1:0] = load_lo_i;
    if (load_hi) cnt_d[CNT_W-1:LO_W] = load_hi_i;
  end

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      alm_q     <= 1'b0;
      lo_prev_q <= 1'b0;
      hi_prev_q <= 1'b0;
      cnt_q     <= '0;
      gray_q    <= '0;
      hit_q     <= 1'b0;
    end else begin
      en_q      <= in_s[0];
      alm_q     <= in_s[1];
      lo_prev_q <= in_s[2];
      hi_prev_q <= in_s[3];
      cnt_q     <= cnt_d;
      gray_q    <= cnt_d ^ (cnt_d >> 1);
      hit_q     <= alm_q && (cnt_q[CNT_W-1:FRAC_W] == alarm_sec_i);
    end
  end

  assign cnt_gray_o = gray_q;
  assign cnt_en_o   = en_q;
  assign hit_o      = hit_q;

  p_cnt_step_r2: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    (en_q && !load_lo && !load_hi) |=> (cnt_q == $past(cnt_q) + CNT_ONE))
    else $error("counter did not advance by one");

  p_gray_one_bit_r2: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    (en_q && !load_lo && !load_hi) |=> ($countones(gray_q ^ $past(gray_q)) == 1))
    else $error("gray step changed more than one bit");

  p_hold_off_r5: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    (!en_q && !load_lo && !load_hi) |=> $stable(cnt_q))
    else $error("stopped counter moved");
endmodule

// File: rtl/lp_rtc_bus_regs.sv
module lp_rtc_bus_regs
  import lp_rtc_pkg::*;
#(
  parameter int unsigned CNT_W  = 47,
  parameter int unsigned FRAC_W = 15,
  localparam int unsigned SEC_W = CNT_W - FRAC_W,
  localparam int unsigned LO_W  = 32,
  localparam int unsigned HI_W  = CNT_W - LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [CNT_W-1:0]  cnt_gray_i,
  input  logic              cnt_en_rb_i,
  input  logic              hit_i,
  output ctrl_t             ctrl_o,
  output logic [SEC_W-1:0]  alarm_o,
  output logic [LO_W-1:0]   load_lo_o,
  output logic [HI_W-1:0]   load_hi_o,
  output logic              lo_tog_o,
  output logic              hi_tog_o,
  output logic              irq_o,
  output logic              wake_o
);
  ctrl_t            ctrl_q;
  logic [SEC_W-1:0] alarm_q;
  logic [LO_W-1:0]  hold_lo_q;
  logic [HI_W-1:0]  hold_hi_q;
  logic             lo_tog_q, hi_tog_q;
  logic [BUS_W-1:0] glitch_q, rdata_q, rd_mux;
  logic             flag_q, hit_prev_q;
  logic             wr, rd, cnt_locked, stat_clr, glitch_flag;
  logic [CNT_W-1:0] cnt_bin;

  assign wr         = req_i & we_i;
  assign rd         = req_i & ~we_i;
  assign cnt_locked = ctrl_q.cnt_en | cnt_en_rb_i;
  assign stat_clr   = wr && (addr_i == OFF_STAT) && wdata_i[STAT_ALM];
  assign glitch_flag = (glitch_q != GLITCH_WORD);

  always_comb begin
    for (int i = 0; i < int'(CNT_W); i++) cnt_bin[i] = ^(cnt_gray_i >> i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      alarm_q    <= '0;
      hold_lo_q  <= '0;
      hold_hi_q  <= '0;
      lo_tog_q   <= 1'b0;
      hi_tog_q   <= 1'b0;
      glitch_q   <= '0;
      flag_q     <= 1'b0;
      hit_prev_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      hit_prev_q <= hit_i;
      if (hit_i && !hit_prev_q) flag_q <= 1'b1;
      else if (stat_clr)        flag_q <= 1'b0;
      if (rd) rdata_q <= rd_mux;
      if (wr) begin
        unique case (addr_i)
          OFF_CTRL: begin
            ctrl_q.cnt_en  <= wdata_i[CTRL_CNT_EN];
            ctrl_q.alm_en  <= wdata_i[CTRL_ALM_EN];
            ctrl_q.wake_en <= wdata_i[CTRL_WAKE_EN];
          end
          OFF_ALARM:  if (!ctrl_q.alm_en) alarm_q <= wdata_i[SEC_W-1:0];
          OFF_CNT_LO: if (!cnt_locked) begin
            hold_lo_q <= wdata_i[LO_W-1:0];
            lo_tog_q  <= ~lo_tog_q;
          end
          OFF_CNT_HI: if (!cnt_locked) begin
            hold_hi_q <= wdata_i[HI_W-1:0];
            hi_tog_q  <= ~hi_tog_q;
          end
          OFF_GLITCH: glitch_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      OFF_CTRL: begin
        rd_mux[CTRL_CNT_EN]  = cnt_en_rb_i;
        rd_mux[CTRL_ALM_EN]  = ctrl_q.alm_en;
        rd_mux[CTRL_WAKE_EN] = ctrl_q.wake_en;
      end
      OFF_STAT: begin
        rd_mux[STAT_ALM]    = flag_q;
        rd_mux[STAT_GLITCH] = glitch_flag;
      end
      OFF_CNT_LO: rd_mux = cnt_bin[LO_W-1:0];
      OFF_CNT_HI: rd_mux[HI_W-1:0] = cnt_bin[CNT_W-1:LO_W];
      OFF_ALARM:  rd_mux[SEC_W-1:0] = alarm_q;
      OFF_GLITCH: rd_mux = glitch_q;
      default:    rd_mux = '0;
    endcase
  end

  assign rdata_o   = rdata_q;
  assign ctrl_o    = ctrl_q;
  assign alarm_o   = alarm_q;
  assign load_lo_o = hold_lo_q;
  assign load_hi_o = hold_hi_q;
  assign lo_tog_o  = lo_tog_q;
  assign hi_tog_o  = hi_tog_q;
  assign irq_o     = flag_q & ctrl_q.alm_en;
  assign wake_o    = flag_q & ctrl_q.wake_en;

  p_cnt_write_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.cnt_en |=> ($stable(lo_tog_q) && $stable(hi_tog_q)))
    else $error("counter load issued while enabled");

  p_alarm_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.alm_en |=> $stable(alarm_q))
    else $error("alarm changed while armed");

  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !stat_clr) |=> flag_q)
    else $error("alarm flag dropped without clear");

  p_glitch_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_GLITCH && wdata_i == GLITCH_WORD) |=> !glitch_flag)
    else $error("glitch flag stuck after pattern write");
endmodule

// File: rtl/lp_rtc.sv
module lp_rtc
  import lp_rtc_pkg::*;
#(
  parameter int unsigned CNT_W       = 47,
  parameter int unsigned FRAC_W      = 15,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              slow_clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int unsigned SEC_W = CNT_W - FRAC_W;
  localparam int unsigned LO_W  = 32;
  localparam int unsigned HI_W  = CNT_W - LO_W;

  ctrl_t            ctrl;
  logic [SEC_W-1:0] alarm;
  logic [LO_W-1:0]  load_lo;
  logic [HI_W-1:0]  load_hi;
  logic             lo_tog, hi_tog;
  logic [CNT_W-1:0] gray_slow, gray_fast;
  logic             en_slow, hit_slow;
  logic [1:0]       back_s;

  lp_rtc_slow_core #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
    .slow_clk_i (slow_clk_i),
    .rst_ni     (rst_ni),
    .cnt_en_i   (ctrl.cnt_en),
    .alm_en_i   (ctrl.alm_en),
    .alarm_sec_i(alarm),
    .lo_tog_i   (lo_tog),
    .hi_tog_i   (hi_tog),
    .load_lo_i  (load_lo),
    .load_hi_i  (load_hi),
    .cnt_gray_o (gray_slow),
    .cnt_en_o   (en_slow),
    .hit_o      (hit_slow)
  );

  lp_rtc_sync #(.WIDTH(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gray_slow),
    .q_o   (gray_fast)
  );

  lp_rtc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_back_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hit_slow, en_slow}),
    .q_o   (back_s)
  );

  lp_rtc_bus_regs #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .cnt_gray_i (gray_fast),
    .cnt_en_rb_i(back_s[0]),
    .hit_i      (back_s[1]),
    .ctrl_o     (ctrl),
    .alarm_o    (alarm),
    .load_lo_o  (load_lo),
    .load_hi_o  (load_hi),
    .lo_tog_o   (lo_tog),
    .hi_tog_o   (hi_tog),
    .irq_o      (irq_o),
    .wake_o     (wake_o)
  );
endmodule

// File: tb/lp_rtc_tb_top.sv
module lp_rtc_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int SLOW_PERIOD = CLK_PERIOD * 8;

  localparam logic [7:0] A_CTRL = 8'h04, A_STAT = 8'h18, A_HI = 8'h1C,
                         A_LO = 8'h20, A_ALM = 8'h24, A_GL = 8'h30;

  logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, wake;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;

  lp_rtc dut_i (
    .clk_i(clk), .slow_clk_i(slow_clk), .rst_ni(rst_n),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_true(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic read_cnt(output logic [46:0] v);
    logic [31:0] h1, l1, h2, l2;
    for (int k = 0; k < 16; k++) begin
      bus_read(A_HI, h1); bus_read(A_LO, l1);
      bus_read(A_HI, h2); bus_read(A_LO, l2);
      if (h1 == h2 && l1 == l2) break;
    end
    v = {h2[14:0], l2};
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(posedge slow_clk);
  endtask

  task automatic wait_rb(input logic v, output int n);
    logic [31:0] d;
    n = 0;
    do begin
      bus_read(A_CTRL, d);
      n++;
    end while (d[0] !== v && n < 200);
  endtask

  task automatic stop_and_load(input logic [31:0] lo, input logic [31:0] hi);
    int n;
    bus_write(A_CTRL, 32'h0);
    wait_rb(1'b0, n);
    bus_write(A_LO, lo);
    bus_write(A_HI, hi);
    wait_slow(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [46:0] a, b, c;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 wake", wake, 0);
    bus_read(A_CTRL, d); check("R1 ctrl", d, 0);
    bus_read(A_STAT, d); check("R1 stat", d, 32'h2);
    bus_read(A_ALM, d);  check("R1 alarm", d, 0);
    read_cnt(a);         check("R1 counter", a, 0);

    // R10 glitch pattern
    bus_write(A_GL, 32'h4173_6166);
    bus_read(A_GL, d);   check("R10 readback", d, 32'h4173_6166);
    bus_read(A_STAT, d); check("R10 cleared", d[1], 0);
    bus_write(A_GL, 32'h4173_6167);
    bus_read(A_STAT, d); check("R10 wrong word", d[1], 1);
    bus_write(A_GL, 32'h4173_6166);

    // R2/R3 load while stopped, high word width
    bus_write(A_LO, 32'h1234_5678);
    bus_write(A_HI, 32'h0000_1ABC);
    wait_slow(6);
    read_cnt(a); check("R3 load accepted", a, 47'h1ABC_1234_5678);
    bus_write(A_HI, 32'hFFFF_FFFF);
    wait_slow(6);
    bus_read(A_HI, d); check("R2 high word bits", d, 32'h0000_7FFF);
    bus_write(A_HI, 32'h0000_1ABC);
    wait_slow(6);

    // R11 unmapped reads with nonzero state
    foreach (d[i]) ;
    bus_read(8'h00, d); check("R11 off 0x00", d, 0);
    bus_read(8'h08, d); check("R11 off 0x08", d, 0);
    bus_read(8'h2C, d); check("R11 off 0x2C", d, 0);
    bus_read(8'hFC, d); check("R11 off 0xFC", d, 0);

    // R4 enable latency
    bus_write(A_CTRL, 32'h1);
    bus_read(A_CTRL, d); check("R4 not immediate", d[0], 0);
    wait_rb(1'b1, n);
    check_true("R4 enable bound", n <= 32, n, 32);

    // R2 running rate
    read_cnt(a);
    wait_slow(50);
    read_cnt(b);
    check_true("R2 rate", (b - a) >= 47 && (b - a) <= 53, b - a, 50);

    // R3 write ignored while running
    bus_write(A_LO, 32'h0);
    bus_write(A_HI, 32'h0);
    wait_slow(6);
    read_cnt(c);
    check_true("R3 write ignored", c > b, c, b);

    // R4/R5 disable and hold
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CTRL, d); check("R4 disable not immediate", d[0], 1);
    wait_rb(1'b0, n);
    check_true("R4 disable bound", n <= 32, n, 32);
    wait_slow(4);
    read_cnt(a);
    wait_slow(20);
    read_cnt(b);
    check("R5 hold", b, a);

    // R2 low-to-high word carry
    stop_and_load(32'hFFFF_FFC0, 32'h5);
    read_cnt(a); check("R3 carry preload", a, 47'h5_FFFF_FFC0);
    bus_write(A_CTRL, 32'h1);
    wait_slow(120);
    bus_write(A_CTRL, 32'h0);
    wait_rb(1'b0, n);
    wait_slow(6);
    read_cnt(a);
    check("R2 high carry", a[46:32], 15'h6);
    check_true("R2 low after carry", a[31:0] > 32'h10 && a[31:0] < 32'h100, a[31:0], 32'h40);

    // R6 alarm disabled: no flag
    stop_and_load(32'h000A_7FC0, 32'h0);
    bus_write(A_ALM, 32'd21);
    bus_write(A_STAT, 32'h1);
    bus_write(A_CTRL, 32'h1);
    wait_slow(120);
    bus_read(A_STAT, d); check("R6 no flag when disabled", d[0], 0);
    check("R9 irq idle", irq, 0);
    read_cnt(a); check("R2 seconds carry", a[46:15], 32'd21);

    // R6 alarm hit
    stop_and_load(32'h0004_FFC0, 32'h0);
    bus_write(A_ALM, 32'd10);
    bus_read(A_ALM, d); check("R7 write while clear", d, 32'd10);
    bus_write(A_STAT, 32'h1);
    bus_write(A_CTRL, 32'hB);
    wait_slow(20);
    bus_read(A_STAT, d); check("R6 before match", d[0], 0);
    check("R9 irq before match", irq, 0);
    bus_write(A_ALM, 32'h55);
    bus_read(A_ALM, d); check("R7 write ignored", d, 32'd10);
    wait_slow(80);
    bus_read(A_STAT, d); check("R6 flag set", d[0], 1);
    check("R9 irq", irq, 1);
    check("R9 wake", wake, 1);
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, d); check("R8 write zero", d[0], 1);

    // R9 gating
    bus_write(A_CTRL, 32'h9);
    @(negedge clk);
    check("R9 irq gated", irq, 0);
    check("R9 wake on", wake, 1);
    bus_write(A_CTRL, 32'h3);
    @(negedge clk);
    check("R9 irq on", irq, 1);
    check("R9 wake gated", wake, 0);

    // R8 clear
    wait_slow(20);
    bus_write(A_STAT, 32'h1);
    wait_slow(10);
    bus_read(A_STAT, d); check("R8 cleared", d[0], 0);
    check("R8 irq low", irq, 0);

    finish_run();
  end
endmodule